// File: doc/BRIEF.md
# GPIO Controller with Sticky Input Status

This block controls eight general-purpose pins from a small register bus with 16-bit data and a 2-bit address. Software sets each pin's direction and a per-pin polarity/driver-type bit. For each pin the block drives a pad output value, a pad output-enable and a weak pull-up enable. Pin levels pass through a two-flop synchronizer. A per-pin sticky flag records that the pin has been at its selected active level since the flag was last cleared.

The polarity/driver-type bit has two uses. On an input pin it chooses the active level, and the pull-up is on only for active-low inputs. On an output pin it chooses between a push-pull driver and an open-drain driver with the pull-up on. The status register returns, per pin, either the live synchronized level or the sticky flag, as the sticky-control register selects. A write to the status register does two things: it clears the chosen sticky flags and it loads the output data. One pin (pin 1 by default) is wired as an input and can never drive. A per-pin alternate-function select hands the pad to another block and overrides the direction setting.

The reset input is the power-on reset. It is the only thing that returns the configuration registers to their defaults.

Top module: `gpio_sticky_ctrl`

## Requirements
- R1: The direction register is at address 0, bits [7:0], and resets to 0x00FF. A bit of 1 makes that pin an input, so its pad output-enable and pad output are 0 unless the alternate function claims the pin. Bits [15:8] of every read are 0.
- R2: Pin 1 is input-only. Its direction bit always reads 1 whatever is written to it, and pad_oe[1] is never asserted, even under the alternate function.
- R3: The polarity register is at address 1 and resets to 0x00FF. On an input, 0 makes high the active level and 1 makes low the active level.
- R4: For a pin not claimed by its alternate function, pad_pu equals its polarity bit. The pull-up is therefore on for active-low inputs and for open-drain outputs, and off otherwise.
- R5: An output pin with polarity 0 is push-pull: pad_oe is 1 and pad_out equals its output data bit.
- R6: An output pin with polarity 1 is open-drain: pad_out is 0 and pad_oe is the inverse of its output data bit.
- R7: The sticky-control register is at address 2 and resets to 0. With a control bit of 0, the status register (address 3) returns that pin's synchronized live level and its sticky flag is held clear.
- R8: With a control bit of 1, the status bit returns the sticky flag. The flag sets when the synchronized level equals the active level and stays set until cleared.
- R9: A write to address 3 clears the sticky flag of each pin whose data bit is 0 and leaves pins whose data bit is 1 unchanged. If the pin is active in that same cycle, the flag stays set.
- R10: A write to address 3 loads bits [7:0] into the output data used by R5 and R6.
- R11: When alt_sel[i] is 1, pad_out[i] is alt_out[i], pad_oe[i] is alt_oe[i] (except pin 1, see R2) and pad_pu[i] is 0. The direction bit is ignored.
- R12: Read data appears on the clock edge after the address is presented. A pin change applied just after an edge shows in a live status read on the third following edge, and not on the second.
- R13: Pad outputs and configuration update only from clocked state. Pad outputs change on the clock edge after the register or alternate-function input that drives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| alt_sel | input | 8 | Per-pin alternate-function claim |
| alt_out | input | 8 | Alternate-function output value |
| alt_oe | input | 8 | Alternate-function output-enable |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output-enable |
| pad_pu | output | 8 | Weak pull-up enable |

## Verification
The hardest case to reach is a status write that tries to clear a sticky flag in the same cycle that its pin is still at the active level. The stimulus holds one pin active through the synchronizer, then writes all zeros to the status register, and reads back to confirm that only that pin's flag survived. Short single-cycle pulses set flags on pins that have already gone inactive by the time of the read. A selective clear with an alternating data pattern and a toggle of sticky-control then show the clear and the forced-clear paths separately.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_DW = 16;
  localparam int BUS_AW = 2;

  typedef enum logic [BUS_AW-1:0] {
    SEL_DIR    = 2'd0,
    SEL_POL    = 2'd1,
    SEL_STKCTL = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
#(
  parameter int               NPINS         = 8,
  parameter logic [NPINS-1:0] FIXED_IN_MASK = 8'h02
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [NPINS-1:0] wr_bits,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] pol_q,
  output logic [NPINS-1:0] stk_q,
  output logic [NPINS-1:0] dout_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      pol_q  <= '1;
      stk_q  <= '0;
      dout_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_DIR:    dir_q  <= wr_bits | FIXED_IN_MASK;
        SEL_POL:    pol_q  <= wr_bits;
        SEL_STKCTL: stk_q  <= wr_bits;
        SEL_STATUS: dout_q <= wr_bits;
        default:    ;
      endcase
    end
  end

  // R2: fixed input pins keep their direction bit at 1
  assert_fixed_input_R2: assert property (@(posedge clk) disable iff (rst)
    (dir_q & FIXED_IN_MASK) == FIXED_IN_MASK);

  // R13: configuration only moves on a write
  assert_cfg_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(dir_q) && $stable(pol_q) && $stable(stk_q)));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_async,
  output logic [NPINS-1:0] pin_sync
);

  logic [NPINS-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= pin_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_sticky.sv
module gpio_sticky #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] ctl,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] sticky_q
);

  logic [NPINS-1:0] hit;
  assign hit = lvl ^ pol;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)          sticky_q[i] <= 1'b0;
      else if (!ctl[i]) sticky_q[i] <= 1'b0;
      else if (hit[i])  sticky_q[i] <= 1'b1;
      else if (clr[i])  sticky_q[i] <= 1'b0;
    end

    // R7: control bit low keeps the flag clear
    assert_forced_clear_R7: assert property (@(posedge clk) disable iff (rst)
      !ctl[i] |=> !sticky_q[i]);
    // R8 and R9: an active level sets the flag even against a clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
      (ctl[i] && hit[i]) |=> sticky_q[i]);
    // R8: the flag is held without a clear
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (ctl[i] && sticky_q[i] && !clr[i]) |=> sticky_q[i]);
    // R9: a clear with the pin inactive drops the flag
    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
      (ctl[i] && !hit[i] && clr[i]) |=> !sticky_q[i]);
  end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int               NPINS         = 8,
  parameter logic [NPINS-1:0] FIXED_IN_MASK = 8'h02
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] dout,
  input  logic [NPINS-1:0] alt_sel,
  input  logic [NPINS-1:0] alt_out,
  input  logic [NPINS-1:0] alt_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic o_d, oe_d, pu_d;

    always_comb begin
      o_d  = 1'b0;
      oe_d = 1'b0;
      pu_d = 1'b0;
      if (alt_sel[i]) begin
        o_d  = alt_out[i];
        oe_d = alt_oe[i] & ~FIXED_IN_MASK[i];
      end else if (dir[i] || FIXED_IN_MASK[i]) begin
        pu_d = pol[i];
      end else if (!pol[i]) begin
        o_d  = dout[i];
        oe_d = 1'b1;
      end else begin
        oe_d = ~dout[i];
        pu_d = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
        pad_pu[i]  <= 1'b0;
      end else begin
        pad_out[i] <= o_d;
        pad_oe[i]  <= oe_d;
        pad_pu[i]  <= pu_d;
      end
    end

    // R1: an input pin does not drive
    assert_input_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      (!alt_sel[i] && dir[i]) |=> (!pad_oe[i] && !pad_out[i]));
    // R4: pull-up follows polarity on pins not claimed by the alternate function
    assert_pullup_R4: assert property (@(posedge clk) disable iff (rst)
      !alt_sel[i] |=> (pad_pu[i] == $past(pol[i])));
    // R5: push-pull output
    assert_push_pull_R5: assert property (@(posedge clk) disable iff (rst)
      (!alt_sel[i] && !dir[i] && !pol[i] && !FIXED_IN_MASK[i]) |=>
        (pad_oe[i] && pad_out[i] == $past(dout[i])));
    // R6: open-drain output never drives high
    assert_open_drain_R6: assert property (@(posedge clk) disable iff (rst)
      (!alt_sel[i] && !dir[i] && pol[i]) |=> (!pad_out[i] && pad_oe[i] == !$past(dout[i])));
    // R11: the alternate function takes the pad
    assert_alt_take_R11: assert property (@(posedge clk) disable iff (rst)
      alt_sel[i] |=> (pad_out[i] == $past(alt_out[i]) && !pad_pu[i]));
  end

  // R2: fixed input pins never drive
  assert_fixed_no_oe_R2: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & FIXED_IN_MASK) == '0);

endmodule

// File: rtl/gpio_sticky_ctrl.sv
module gpio_sticky_ctrl
  import gpio_pkg::*;
#(
  parameter int               NPINS         = 8,
  parameter int               SYNC_STAGES   = 2,
  parameter logic [NPINS-1:0] FIXED_IN_MASK = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [BUS_DW-1:0] wdata,
  output logic [BUS_DW-1:0] rdata,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  alt_sel,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu
);

  reg_sel_e         sel;
  logic [NPINS-1:0] wr_bits;
  logic [NPINS-1:0] dir_q, pol_q, stk_q, dout_q;
  logic [NPINS-1:0] lvl_sync, sticky_q, clr_mask, status_v;
  logic [BUS_DW-1:0] rd_next;

  assign sel      = reg_sel_e'(addr);
  assign wr_bits  = wdata[NPINS-1:0];
  assign clr_mask = (wr_en && sel == SEL_STATUS) ? ~wr_bits : '0;

  gpio_cfg_regs #(.NPINS(NPINS), .FIXED_IN_MASK(FIXED_IN_MASK)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(sel), .wr_bits(wr_bits),
    .dir_q(dir_q), .pol_q(pol_q), .stk_q(stk_q), .dout_q(dout_q)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_async(pin_in), .pin_sync(lvl_sync)
  );

  gpio_sticky #(.NPINS(NPINS)) u_sticky (
    .clk(clk), .rst(rst), .lvl(lvl_sync), .pol(pol_q), .ctl(stk_q),
    .clr(clr_mask), .sticky_q(sticky_q)
  );

  gpio_pad_drive #(.NPINS(NPINS), .FIXED_IN_MASK(FIXED_IN_MASK)) u_pad (
    .clk(clk), .rst(rst), .dir(dir_q), .pol(pol_q), .dout(dout_q),
    .alt_sel(alt_sel), .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_stat
    assign status_v[i] = stk_q[i] ? sticky_q[i] : lvl_sync[i];
  end

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_DIR:    rd_next[NPINS-1:0] = dir_q;
      SEL_POL:    rd_next[NPINS-1:0] = pol_q;
      SEL_STKCTL: rd_next[NPINS-1:0] = stk_q;
      SEL_STATUS: rd_next[NPINS-1:0] = status_v;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R1: bits above the pin count read as zero
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (rdata >> NPINS) == '0);

endmodule

// File: tb/tb_gpio_sticky_ctrl.sv
module tb_gpio_sticky_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  pin_in = '0, alt_sel = '0, alt_out = '0, alt_oe = '0;
  logic [7:0]  pad_out, pad_oe, pad_pu;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_sticky_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .alt_sel(alt_sel), .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  function automatic void exp_pad(input logic [7:0] dv, pv, ov, as, ao, aoe,
                                  output logic [7:0] eo, eoe, epu);
    logic [7:0] d;
    d = dv | 8'h02;
    for (int i = 0; i < 8; i++) begin
      if (as[i]) begin
        eo[i] = ao[i]; eoe[i] = aoe[i] & (i != 1); epu[i] = 1'b0;
      end else if (d[i]) begin
        eo[i] = 1'b0; eoe[i] = 1'b0; epu[i] = pv[i];
      end else if (!pv[i]) begin
        eo[i] = ov[i]; eoe[i] = 1'b1; epu[i] = 1'b0;
      end else begin
        eo[i] = 1'b0; eoe[i] = ~ov[i]; epu[i] = 1'b1;
      end
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0] eo, eoe, epu;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Reset state (R1, R3, R7, R4)
    rd(2'd0, v); chk("R1 dir reset", v, 16'h00FF);
    rd(2'd1, v); chk("R3 pol reset", v, 16'h00FF);
    rd(2'd2, v); chk("R7 stkctl reset", v, 16'h0000);
    chk("R1 oe after reset", {8'h0, pad_oe}, 16'h0000);
    chk("R4 pu after reset", {8'h0, pad_pu}, 16'h00FF);

    // Pin 1 fixed input, upper bits read zero (R2, R1)
    wr(2'd0, 16'h0000); rd(2'd0, v); chk("R2 dir bit1 stays", v, 16'h0002);
    wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R1 upper bits zero", v, 16'h00FF);

    // Pad sweep over direction, polarity, data and alternate function (R4 R5 R6 R10 R11 R13)
    for (int k = 0; k < 48; k++) begin
      logic [7:0] dv, pv, ov, as, ao, aoe;
      dv  = 8'(k * 29 + 3);
      pv  = 8'(k * 53 + 7);
      ov  = 8'(k * 91 + 11);
      as  = (k >= 32) ? 8'(k * 17 + 2) : 8'h00;
      ao  = 8'(k * 5);
      aoe = 8'(k * 13 + 1);
      wr(2'd0, {8'h0, dv});
      wr(2'd1, {8'h0, pv});
      wr(2'd3, {8'h0, ov});
      alt_sel = as; alt_out = ao; alt_oe = aoe;
      repeat (2) @(negedge clk);
      exp_pad(dv, pv, ov, as, ao, aoe, eo, eoe, epu);
      chk("R5/R6/R10/R11 pad_out", {8'h0, pad_out}, {8'h0, eo});
      chk("R2/R5/R6/R11 pad_oe", {8'h0, pad_oe}, {8'h0, eoe});
      chk("R4 pad_pu", {8'h0, pad_pu}, {8'h0, epu});
    end
    alt_sel = '0;

    // R13: pad follows one edge after the write
    wr(2'd1, 16'h0000); wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0001);
    chk("R13 pad not yet updated", {15'h0, pad_out[0]}, 16'h0000);
    @(negedge clk);
    chk("R13 pad updated", {15'h0, pad_out[0]}, 16'h0001);

    // Live level walk (R7) and sync latency (R12)
    wr(2'd0, 16'h00FF);
    wr(2'd2, 16'h0000);
    for (int i = 0; i < 8; i++) begin
      pin_in = 8'(1 << i);
      repeat (3) @(negedge clk);
      rd(2'd3, v); chk("R7 live level", v, {8'h0, 8'(1 << i)});
    end
    @(negedge clk); addr = 2'd3; pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'hA5;
    repeat (2) @(negedge clk);
    chk("R12 not visible after two edges", rdata, 16'h0000);
    @(negedge clk);
    chk("R12 visible after three edges", rdata, 16'h00A5);

    // Sticky behaviour (R3 R8 R9): pins 0-3 active-low, pins 4-7 active-high
    wr(2'd1, 16'h000F);
    pin_in = 8'h0F;
    repeat (3) @(negedge clk);
    wr(2'd2, 16'h00FF);
    wr(2'd3, 16'h0000);
    rd(2'd3, v); chk("R8 no flags while inactive", v, 16'h0000);
    @(negedge clk); pin_in = 8'hF0;
    @(negedge clk); pin_in = 8'h0F;
    repeat (4) @(negedge clk);
    rd(2'd3, v); chk("R3/R8 pulse sets flags", v, 16'h00FF);
    wr(2'd3, 16'h0055);
    rd(2'd3, v); chk("R9 selective clear", v, 16'h0055);
    pin_in = 8'h8F;
    repeat (3) @(negedge clk);
    wr(2'd3, 16'h0000);
    rd(2'd3, v); chk("R9 set beats clear", v, 16'h0080);
    pin_in = 8'h0F;
    repeat (3) @(negedge clk);
    wr(2'd3, 16'h0000);
    rd(2'd3, v); chk("R9 clear after inactive", v, 16'h0000);
    @(negedge clk); pin_in = 8'h0E;
    @(negedge clk); pin_in = 8'h0F;
    repeat (4) @(negedge clk);
    wr(2'd2, 16'h00FE);
    rd(2'd3, v); chk("R7 live read of pin0", v, 16'h0001);
    wr(2'd2, 16'h00FF);
    rd(2'd3, v); chk("R7 flag was held clear", v, 16'h0000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule